// File: doc/BRIEF.md
# Separable Virtual-Channel and Switch Allocator

This block decides, every cycle, which buffered flits of a P-port mesh router may cross the crossbar. Each input port keeps V virtual channels, and each of them names at most one output port it wants to reach. The allocator first settles which input owns each downstream virtual channel. Among the channels that own a downstream channel with room, it then picks at most one per input port and at most one input per output port. The result goes back to the input buffers as a per-input winning-channel vector and forward to the crossbar as a registered per-output select.

All arbitration uses round-robin arbiters that can repeat their previous grant. The ownership arbiters use this to keep a downstream channel with one packet until that packet's last flit has been switched. The switch-stage arbiters always arbitrate afresh. An arbiter's priority only rotates when its grant is actually used.

Top module: `vcsw_allocator`

## Requirements
- R1: `req_i` bit (ip*V+v)*P+op asks for output op on behalf of channel v of input ip. `on_off_i` bit op*V+v high means downstream channel v behind output op can accept a flit. `tail_i` and `vc_grant_o` bit ip*V+v belong to channel v of input ip. `xbar_sel_o` bit op*P+ip high routes input ip to output op. A lone eligible request is granted in the same cycle.
- R2: While input A owns channel v on output op, a request from another input B for that same channel and output is not granted.
- R3: Ownership of a downstream channel ends after the cycle in which the owner's channel was granted with `tail_i` high. From the next cycle other inputs may win it.
- R4: When several inputs compete afresh for a downstream channel, or for an output in the switch stage, the winner is the first requester at or after the position just past the last granted one, in cyclic order. After reset, index 0 has top priority. Priority moves only when a grant is issued and used.
- R5: A channel whose downstream channel has `on_off_i` low is not granted. It keeps its ownership while blocked.
- R6: At most one channel per input port is granted per cycle.
- R7: At most one input is granted per output port per cycle, and each output's select is zero or one-hot.
- R8: `xbar_sel_o` shows, one cycle after a grant, the granted input routed to the output its winning channel requested.
- R9: Synchronous active-low reset clears every ownership, every priority pointer and `xbar_sel_o`.
- R10: Grants towards different output ports are issued in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_i | input | P*V*P | Output-port request per input channel |
| tail_i | input | P*V | Head flit of that channel is a packet's last flit |
| on_off_i | input | P*V | Downstream channel has room, per output and channel |
| vc_grant_o | output | P*V | Winning channel per input, fed back to buffers |
| xbar_sel_o | output | P*P | Registered crossbar select, per output one-hot input |

## Verification
The bench builds the block with three ports and two virtual channels. Three inputs are enough to show a rotating pointer skipping over a non-requesting position. Two channels per input let one input hold one downstream channel while another input owns the second channel on the same output. The default five-port build is exercised only by elaboration. The small build brings hold, release, backpressure, two-stage switch contention and the reset of priority pointers within a short vector table.

// File: rtl/vcsw_alloc_pkg.sv
// Shared definitions for the virtual-channel / switch allocator.
// Assumes nothing beyond IEEE 1800-2017.
package vcsw_alloc_pkg;

    // Whether an arbiter may repeat its previous grant.
    typedef enum logic {
        HOLD_OFF = 1'b0,
        HOLD_ON  = 1'b1
    } hold_mode_e;

endpackage

// File: rtl/rr_hold_arbiter.sv
// Round-robin arbiter with optional grant hold.
// What: grants one requester per cycle. The search starts at a rotating
// pointer. With HOLD_ON, a previous grant that is still requested and was
// not released is repeated instead of a fresh pick.
// Assumes: adv_i says whether a grant was consumed; the pointer only moves then.
module rr_hold_arbiter
    import vcsw_alloc_pkg::*;
#(
    parameter int         N    = 4,
    parameter hold_mode_e MODE = HOLD_ON
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] req_i,
    input  logic         adv_i,
    input  logic [N-1:0] release_i,
    output logic [N-1:0] grant_o
);
    localparam int PW = (N > 1) ? $clog2(N) : 1;

    logic [PW-1:0] ptr_q;
    logic [N-1:0]  fresh;
    logic [N-1:0]  hold_vec;
    logic [PW-1:0] gnt_idx;
    logic [PW-1:0] ptr_next;

    // Fresh pick: first requester at or after the pointer, cyclically.
    always_comb begin
        int  idx;
        logic found;
        fresh = '0;
        found = 1'b0;
        idx   = 0;
        for (int k = 0; k < N; k++) begin
            idx = (int'(ptr_q) + k) % N;
            if (!found && req_i[idx]) begin
                found      = 1'b1;
                fresh[idx] = 1'b1;
            end
        end
    end

    generate
        if (MODE == HOLD_ON) begin : g_hold
            logic [N-1:0] last_q;

            // Remember the grant unless its owner released it this cycle.
            always_ff @(posedge clk) begin
                if (!rst_n) last_q <= '0;
                else        last_q <= grant_o & ~release_i;
            end

            assign hold_vec = last_q & req_i;

            // A live, unreleased grant that is still requested is repeated.
            p_hold_keeps_r3: assert property (@(posedge clk) disable iff (!rst_n)
                (|(grant_o & ~release_i)) |=>
                    (((($past(grant_o) & req_i)) == '0) || (grant_o == $past(grant_o))));
        end else begin : g_nohold
            logic unused_release;
            assign unused_release = ^release_i;
            assign hold_vec       = '0;
        end
    endgenerate

    // Final grant: the held grant wins over a fresh pick.
    assign grant_o = (|hold_vec) ? hold_vec : fresh;

    // Index of the issued grant and the pointer just past it.
    always_comb begin
        gnt_idx = '0;
        for (int k = 0; k < N; k++) begin
            if (grant_o[k]) gnt_idx = PW'(k);
        end
        ptr_next = (int'(gnt_idx) == N - 1) ? '0 : gnt_idx + PW'(1);
    end

    // Rotate priority only when a grant was issued and used.
    always_ff @(posedge clk) begin
        if (!rst_n)                 ptr_q <= '0;
        else if (adv_i && |grant_o) ptr_q <= ptr_next;
    end

    p_grant_onehot_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(grant_o));

    p_grant_requested_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (grant_o & ~req_i) == '0);

endmodule

// File: rtl/vc_alloc_stage.sv
// Virtual-channel allocation.
// What: one holding arbiter per (output port, channel) chooses which input
// owns that downstream channel. A channel is eligible for the switch stage
// when it owns its downstream channel and that channel has room.
// Assumes: each input channel requests at most one output, so no
// input-side arbitration stage is needed.
module vc_alloc_stage
    import vcsw_alloc_pkg::*;
#(
    parameter int P = 5,
    parameter int V = 2
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [P*V*P-1:0] req_i,
    input  logic [P*V-1:0] on_off_i,
    input  logic [P*V-1:0] release_i,
    output logic [P*V-1:0] va_ok_o
);
    localparam int NARB = P * V;

    // Grant of arbiter (op, v) is held at bits (op*V+v)*P +: P, indexed by input.
    logic [NARB*P-1:0] own_gnt;

    generate
        for (genvar op = 0; op < P; op++) begin : g_op
            for (genvar v = 0; v < V; v++) begin : g_vc
                logic [P-1:0] col_req;
                logic [P-1:0] col_rel;
                for (genvar ip = 0; ip < P; ip++) begin : g_ip
                    assign col_req[ip] = req_i[(ip*V+v)*P+op];
                    assign col_rel[ip] = release_i[ip*V+v];
                end
                rr_hold_arbiter #(.N(P), .MODE(HOLD_ON)) u_own_arb (
                    .clk       (clk),
                    .rst_n     (rst_n),
                    .req_i     (col_req),
                    .adv_i     (1'b1),
                    .release_i (col_rel),
                    .grant_o   (own_gnt[(op*V+v)*P +: P])
                );
            end
        end
    endgenerate

    // A channel is eligible when it owns a downstream channel that has room.
    always_comb begin
        va_ok_o = '0;
        for (int ip = 0; ip < P; ip++) begin
            for (int v = 0; v < V; v++) begin
                for (int op = 0; op < P; op++) begin
                    if (own_gnt[(op*V+v)*P+ip] && on_off_i[op*V+v])
                        va_ok_o[ip*V+v] = 1'b1;
                end
            end
        end
    end

endmodule

// File: rtl/sw_alloc_stage.sv
// Switch allocation, input-first separable.
// What: per input, a round-robin arbiter picks one eligible channel. The
// output that channel requests enters a per-output arbiter, which picks one
// input. The input-level grant, ANDed with the input's channel pick, is the
// channel grant and also advances the input arbiter.
// Assumes: each request vector of a channel is zero or one-hot.
module sw_alloc_stage
    import vcsw_alloc_pkg::*;
#(
    parameter int P = 5,
    parameter int V = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [P*V*P-1:0] req_i,
    input  logic [P*V-1:0]   va_ok_i,
    output logic [P*V-1:0]   vc_grant_o,
    output logic [P*P-1:0]   dest_o,
    output logic [P-1:0]     in_gnt_o
);
    logic [P*V-1:0] s1_gnt;
    logic [P*P-1:0] s2_gnt;

    generate
        for (genvar ip = 0; ip < P; ip++) begin : g_in
            rr_hold_arbiter #(.N(V), .MODE(HOLD_OFF)) u_vc_arb (
                .clk       (clk),
                .rst_n     (rst_n),
                .req_i     (va_ok_i[ip*V +: V]),
                .adv_i     (in_gnt_o[ip]),
                .release_i ({V{1'b1}}),
                .grant_o   (s1_gnt[ip*V +: V])
            );
        end
        for (genvar op = 0; op < P; op++) begin : g_out
            logic [P-1:0] col_req;
            for (genvar ip = 0; ip < P; ip++) begin : g_ip
                assign col_req[ip] = dest_o[ip*P+op];
            end
            rr_hold_arbiter #(.N(P), .MODE(HOLD_OFF)) u_port_arb (
                .clk       (clk),
                .rst_n     (rst_n),
                .req_i     (col_req),
                .adv_i     (1'b1),
                .release_i ({P{1'b1}}),
                .grant_o   (s2_gnt[op*P +: P])
            );
        end
    endgenerate

    // Destination of each input's winning channel, one-hot per input.
    always_comb begin
        dest_o = '0;
        for (int ip = 0; ip < P; ip++)
            for (int v = 0; v < V; v++)
                for (int op = 0; op < P; op++)
                    if (s1_gnt[ip*V+v] && req_i[(ip*V+v)*P+op])
                        dest_o[ip*P+op] = 1'b1;
    end

    // Input-level grant: OR of every output arbiter's grant to that input.
    always_comb begin
        in_gnt_o = '0;
        for (int op = 0; op < P; op++)
            for (int ip = 0; ip < P; ip++)
                if (s2_gnt[op*P+ip]) in_gnt_o[ip] = 1'b1;
    end

    // Channel grant fed back to the buffers.
    always_comb begin
        for (int ip = 0; ip < P; ip++)
            vc_grant_o[ip*V +: V] = s1_gnt[ip*V +: V] & {V{in_gnt_o[ip]}};
    end

    generate
        for (genvar ip = 0; ip < P; ip++) begin : g_chk
            p_one_vc_per_input_r6: assert property (@(posedge clk) disable iff (!rst_n)
                $onehot0(vc_grant_o[ip*V +: V]));
            p_grant_was_eligible_r5: assert property (@(posedge clk) disable iff (!rst_n)
                (vc_grant_o[ip*V +: V] & ~va_ok_i[ip*V +: V]) == '0);
        end
    endgenerate

endmodule

// File: rtl/vcsw_allocator.sv
// Combined virtual-channel and switch allocator, top level.
// What: chains ownership (VC) allocation and separable switch allocation,
// releases ownership when a tail flit is granted, and registers the
// crossbar select as input grant ANDed with the winning destination.
// Assumes: buffers present one flit per channel and flag its tail.
module vcsw_allocator #(
    parameter int P = 5,
    parameter int V = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [P*V*P-1:0] req_i,
    input  logic [P*V-1:0]   tail_i,
    input  logic [P*V-1:0]   on_off_i,
    output logic [P*V-1:0]   vc_grant_o,
    output logic [P*P-1:0]   xbar_sel_o
);
    localparam int NSEL = P * P;

    logic [P*V-1:0]  va_ok;
    logic [P*V-1:0]  rel;
    logic [NSEL-1:0] dest;
    logic [P-1:0]    in_gnt;
    logic [NSEL-1:0] xbar_d;

    // Ownership ends when the owner's tail flit is switched.
    assign rel = tail_i & vc_grant_o;

    vc_alloc_stage #(.P(P), .V(V)) u_vc_stage (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_i     (req_i),
        .on_off_i  (on_off_i),
        .release_i (rel),
        .va_ok_o   (va_ok)
    );

    sw_alloc_stage #(.P(P), .V(V)) u_sw_stage (
        .clk        (clk),
        .rst_n      (rst_n),
        .req_i      (req_i),
        .va_ok_i    (va_ok),
        .vc_grant_o (vc_grant_o),
        .dest_o     (dest),
        .in_gnt_o   (in_gnt)
    );

    // Crossbar select: input grant ANDed with its destination, per output.
    always_comb begin
        for (int op = 0; op < P; op++)
            for (int ip = 0; ip < P; ip++)
                xbar_d[op*P+ip] = in_gnt[ip] & dest[ip*P+op];
    end

    // Register the crossbar select.
    always_ff @(posedge clk) begin
        if (!rst_n) xbar_sel_o <= '0;
        else        xbar_sel_o <= xbar_d;
    end

    generate
        for (genvar op = 0; op < P; op++) begin : g_out_chk
            p_xbar_onehot_r7: assert property (@(posedge clk) disable iff (!rst_n)
                $onehot0(xbar_sel_o[op*P +: P]));
            for (genvar ip = 0; ip < P; ip++) begin : g_in_chk
                p_xbar_after_grant_r8: assert property (@(posedge clk) disable iff (!rst_n)
                    xbar_sel_o[op*P+ip] |-> $past(|vc_grant_o[ip*V +: V]));
            end
            for (genvar v = 0; v < V; v++) begin : g_vc_chk
                for (genvar ip = 0; ip < P; ip++) begin : g_bp
                    p_no_grant_when_full_r5: assert property (@(posedge clk) disable iff (!rst_n)
                        (vc_grant_o[ip*V+v] && req_i[(ip*V+v)*P+op]) |-> on_off_i[op*V+v]);
                end
            end
        end
    endgenerate

endmodule

// File: tb/vcsw_allocator_bench.sv
module vcsw_allocator_bench;
    localparam int P  = 3;
    localparam int V  = 2;
    localparam int NR = 8;

    logic             clk = 1'b0;
    logic             rst_n;
    logic [P*V*P-1:0] req_i;
    logic [P*V-1:0]   tail_i;
    logic [P*V-1:0]   on_off_i;
    logic [P*V-1:0]   vc_grant_o;
    logic [P*P-1:0]   xbar_sel_o;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #4 clk = ~clk;

    vcsw_allocator #(.P(P), .V(V)) u_vcsw_allocator (
        .clk        (clk),
        .rst_n      (rst_n),
        .req_i      (req_i),
        .tail_i     (tail_i),
        .on_off_i   (on_off_i),
        .vc_grant_o (vc_grant_o),
        .xbar_sel_o (xbar_sel_o)
    );

    // Stimulus and expectations; xbar column is the select seen before the row's edge.
    localparam logic [17:0] T_REQ  [NR] = '{18'h00002, 18'h00104, 18'h00104, 18'h00104,
                                            18'h00104, 18'h00124, 18'h00124, 18'h01020};
    localparam logic [5:0]  T_TAIL [NR] = '{6'h01, 6'h00, 6'h01, 6'h00,
                                            6'h00, 6'h00, 6'h04, 6'h00};
    localparam logic [5:0]  T_ONOF [NR] = '{6'h3F, 6'h3F, 6'h3F, 6'h3F,
                                            6'h2F, 6'h3F, 6'h3F, 6'h3F};
    localparam logic [5:0]  T_VCG  [NR] = '{6'h01, 6'h01, 6'h01, 6'h04,
                                            6'h00, 6'h02, 6'h04, 6'h12};
    localparam logic [8:0]  T_XB   [NR] = '{9'h000, 9'h008, 9'h040, 9'h040,
                                            9'h080, 9'h000, 9'h040, 9'h080};

    function automatic string row_tag(int r);
        case (r)
            0: return "R1";
            1: return "R4";
            2: return "R2";
            3: return "R3";
            4: return "R5";
            5: return "R7";
            6: return "R3";
            default: return "R10";
        endcase
    endfunction

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    task automatic drive(logic [17:0] r, logic [5:0] t, logic [5:0] o);
        req_i    = r;
        tail_i   = t;
        on_off_i = o;
    endtask

    initial begin
        rst_n = 1'b0;
        drive('0, '0, 6'h3F);
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        check("R9 reset xbar", 32'(xbar_sel_o), 32'h0);
        check("R9 reset grant", 32'(vc_grant_o), 32'h0);

        for (int r = 0; r < NR; r++) begin
            @(negedge clk);
            drive(T_REQ[r], T_TAIL[r], T_ONOF[r]);
            #1;
            check(row_tag(r), 32'(vc_grant_o), 32'(T_VCG[r]));
            check("R8", 32'(xbar_sel_o), 32'(T_XB[r]));
        end

        // R8/R10: two outputs selected together after the last row.
        @(negedge clk);
        drive('0, '0, 6'h3F);
        #1;
        check("R8 R10 parallel select", 32'(xbar_sel_o), 32'h044);
        rst_n = 1'b0;
        @(negedge clk);
        #1;
        check("R9 select cleared", 32'(xbar_sel_o), 32'h0);
        rst_n = 1'b1;

        // R9: pointer back at 0 picks input 1 over input 2 for op2/ch0.
        @(negedge clk);
        drive(18'h04100, '0, 6'h3F);
        #1;
        check("R9 pointer reset", 32'(vc_grant_o), 32'h04);

        // R6: input 0 offers two channels to different outputs; one wins.
        @(negedge clk);
        drive(18'h00011, '0, 6'h3F);
        #1;
        check("R6 one channel per input", 32'(vc_grant_o), 32'h01);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #(8 * 20000);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule